// File: doc/BRIEF.md
# Privileged trap entry controller

This block performs the state update a processor core makes when it takes a trap. A one-cycle strobe delivers the trap: whether it is an interrupt or an exception, the cause number, the faulting address and the program counter of the trapping instruction. The surrounding CSR file supplies the current privilege level and the machine and supervisor interrupt-enable bits. The same CSR file also supplies the exception and interrupt delegation masks and the two handler base registers.

From these inputs the block picks the handler level: machine or supervisor. It then produces, one cycle later and all from registers, the new status fields, the cause, exception-PC and trap-value registers of the chosen level, the new privilege and the handler address. A done pulse marks that cycle. A reservation-clear pulse is raised in the same cycle whenever the trap moves the hart to a different privilege level. An environment-call exception reaches the block under one cause code and is renumbered according to the mode it was raised from.

Top module: `trap_entry_ctrl`

## Requirements
- R1: The trap is taken at supervisor level (priv encoding 1) only when the current privilege is user (0) or supervisor (1) and the selected delegation bit for the reported cause is set. Otherwise it is taken at machine level (encoding 3). A trap raised in machine mode always stays in machine mode.
- R2: Interrupts (async=1) select their delegation bit from `int_deleg`, exceptions from `exc_deleg`, indexed by the reported cause. A cause value of XLEN or more is never delegated.
- R3: At the destination level, the previous-enable bit takes that level's current enable input, the previous-privilege field takes the current privilege (`spp` takes bit 0 of it), and the enable bit is cleared. The other level's status fields keep their values.
- R4: The destination cause register holds the reported cause zero-extended, with bit XLEN-1 set to the async flag.
- R5: The handler address is the destination base register with bits 1:0 cleared. When the trap is an interrupt and the base register's bits 1:0 equal 1, four times the cause is added. Any other mode value (0, 2, 3), and every exception, gives the base alone.
- R6: The destination trap-value register takes `trap_addr` for exceptions with cause 0, 1, 4, 5, 6, 7, 12, 13 or 15. For every other exception, and for every interrupt, it takes zero.
- R7: An exception with cause 8 is reported as cause 8 from user mode, 9 from supervisor mode and 11 from machine mode. The renumbered value is the one used for delegation, the cause register and the vector offset. An interrupt with cause 8 is not renumbered.
- R8: The destination exception-PC register takes `trap_pc`, and the privilege output switches to the destination level.
- R9: `resv_clear` pulses, in the same cycle as `trap_done`, exactly when the destination level differs from the current privilege.
- R10: All outputs are registered. `trap_done` is high for exactly the cycle after the strobe, and no output changes without a strobe. Reset gives privilege 3 and zero for every other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_valid | input | 1 | One-cycle trap strobe |
| trap_async | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Raw cause number |
| trap_addr | input | XLEN | Faulting address |
| trap_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cur_mie | input | 1 | Current machine interrupt enable |
| cur_sie | input | 1 | Current supervisor interrupt enable |
| exc_deleg | input | XLEN | Exception delegation mask |
| int_deleg | input | XLEN | Interrupt delegation mask |
| m_tvec | input | XLEN | Machine handler base, bits 1:0 mode |
| s_tvec | input | XLEN | Supervisor handler base, bits 1:0 mode |
| priv | output | 2 | Privilege after the trap |
| mie | output | 1 | Machine interrupt enable |
| mpie | output | 1 | Machine previous enable |
| mpp | output | 2 | Machine previous privilege |
| sie | output | 1 | Supervisor interrupt enable |
| spie | output | 1 | Supervisor previous enable |
| spp | output | 1 | Supervisor previous privilege |
| mcause | output | XLEN | Machine cause register |
| mepc | output | XLEN | Machine exception PC |
| mtval | output | XLEN | Machine trap value |
| scause | output | XLEN | Supervisor cause register |
| sepc | output | XLEN | Supervisor exception PC |
| stval | output | XLEN | Supervisor trap value |
| next_pc | output | XLEN | Handler address |
| trap_done | output | 1 | Pulse one cycle after the strobe |
| resv_clear | output | 1 | Pulse when the privilege level changes |

## Verification
The two functions that meet in one cycle are the environment-call renumbering and the delegation lookup: the renumbered cause, not the raw one, must pick the delegation bit. The sweep provokes this with masks that set bit 9 but not bit 8, and then bit 8 alone, and raises cause 8 from each mode. It judges the result by the destination level, the cause value written and, for interrupts on a vectored base, the handler offset, all predicted arithmetically. Vector offset and trap-value selection for causes beyond the mask width fall in the same sweep.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int ECALL_FROM_U = 8;
    localparam int ECALL_FROM_S = 9;
    localparam int ECALL_FROM_M = 11;

    localparam logic [1:0] VEC_MODE_TABLE = 2'd1;

    // Exception causes that report the faulting address
    function automatic logic cause_has_addr(input int code);
        case (code)
            0, 1, 4, 5, 6, 7, 12, 13, 15: cause_has_addr = 1'b1;
            default:                      cause_has_addr = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic               is_async,
    input  logic [CAUSE_W-1:0] raw_cause,
    input  logic [1:0]         cur_priv,
    input  logic [XLEN-1:0]    exc_deleg,
    input  logic [XLEN-1:0]    int_deleg,
    output logic [CAUSE_W-1:0] eff_cause,
    output logic               to_super
);

    localparam logic [CAUSE_W-1:0] CODE_U = CAUSE_W'(ECALL_FROM_U);
    localparam logic [CAUSE_W-1:0] CODE_S = CAUSE_W'(ECALL_FROM_S);
    localparam logic [CAUSE_W-1:0] CODE_M = CAUSE_W'(ECALL_FROM_M);

    logic [XLEN-1:0] mask_sel;
    logic            deleg_bit;

    always_comb begin
        eff_cause = raw_cause;
        if (!is_async && raw_cause == CODE_U) begin
            case (cur_priv)
                PRIV_S:  eff_cause = CODE_S;
                PRIV_M:  eff_cause = CODE_M;
                default: eff_cause = CODE_U;
            endcase
        end
    end

    assign mask_sel = is_async ? int_deleg : exc_deleg;

    // Bit lookup by comparison; causes with no mask bit stay undelegated
    always_comb begin
        deleg_bit = 1'b0;
        for (int i = 0; i < XLEN; i++) begin
            if (32'(eff_cause) == i) deleg_bit = mask_sel[i];
        end
    end

    assign to_super = (cur_priv != PRIV_M) && deleg_bit;

endmodule

// File: rtl/trap_vector.sv
module trap_vector
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic [XLEN-1:0]    tvec,
    input  logic               is_async,
    input  logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    handler_pc
);

    localparam int PAD_W = XLEN - CAUSE_W - 2;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    assign base   = {tvec[XLEN-1:2], 2'b00};
    assign offset = (is_async && tvec[1:0] == VEC_MODE_TABLE)
                  ? {{PAD_W{1'b0}}, cause, 2'b00} : '0;
    assign handler_pc = base + offset;

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               trap_async,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_addr,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic [1:0]         cur_priv,
    input  logic               cur_mie,
    input  logic               cur_sie,
    input  logic [XLEN-1:0]    exc_deleg,
    input  logic [XLEN-1:0]    int_deleg,
    input  logic [XLEN-1:0]    m_tvec,
    input  logic [XLEN-1:0]    s_tvec,
    output logic [1:0]         priv,
    output logic               mie,
    output logic               mpie,
    output logic [1:0]         mpp,
    output logic               sie,
    output logic               spie,
    output logic               spp,
    output logic [XLEN-1:0]    mcause,
    output logic [XLEN-1:0]    mepc,
    output logic [XLEN-1:0]    mtval,
    output logic [XLEN-1:0]    scause,
    output logic [XLEN-1:0]    sepc,
    output logic [XLEN-1:0]    stval,
    output logic [XLEN-1:0]    next_pc,
    output logic               trap_done,
    output logic               resv_clear
);

    localparam int CPAD_W  = XLEN - 1 - CAUSE_W;
    localparam int N_LEVEL = 2;   // index 0 machine, 1 supervisor

    typedef struct packed {
        logic [1:0]      priv;
        logic            mie;
        logic            mpie;
        logic [1:0]      mpp;
        logic            sie;
        logic            spie;
        logic            spp;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] mtval;
        logic [XLEN-1:0] scause;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] stval;
        logic [XLEN-1:0] next_pc;
        logic            done;
        logic            resv_clr;
    } trap_state_t;

    trap_state_t st_d, st_q;

    logic [CAUSE_W-1:0] eff_cause;
    logic               to_super;
    logic [XLEN-1:0]    cause_word;
    logic [XLEN-1:0]    tval_word;
    logic [1:0]         dest_priv;
    logic [XLEN-1:0]    tvec_sel   [N_LEVEL];
    logic [XLEN-1:0]    handler_pc [N_LEVEL];

    trap_route #(
        .XLEN    (XLEN),
        .CAUSE_W (CAUSE_W)
    ) u_route (
        .is_async  (trap_async),
        .raw_cause (trap_cause),
        .cur_priv  (cur_priv),
        .exc_deleg (exc_deleg),
        .int_deleg (int_deleg),
        .eff_cause (eff_cause),
        .to_super  (to_super)
    );

    assign tvec_sel[0] = m_tvec;
    assign tvec_sel[1] = s_tvec;

    // One handler-address unit per level, in parallel with the routing
    for (genvar g = 0; g < N_LEVEL; g++) begin : g_vec
        trap_vector #(
            .XLEN    (XLEN),
            .CAUSE_W (CAUSE_W)
        ) u_vec (
            .tvec       (tvec_sel[g]),
            .is_async   (trap_async),
            .cause      (eff_cause),
            .handler_pc (handler_pc[g])
        );
    end

    assign cause_word = {trap_async, {CPAD_W{1'b0}}, eff_cause};
    assign tval_word  = (!trap_async && cause_has_addr(32'(eff_cause)))
                      ? trap_addr : '0;
    assign dest_priv  = to_super ? PRIV_S : PRIV_M;

    always_comb begin
        st_d          = st_q;
        st_d.done     = 1'b0;
        st_d.resv_clr = 1'b0;
        if (trap_valid) begin
            st_d.done     = 1'b1;
            st_d.priv     = dest_priv;
            st_d.resv_clr = (dest_priv != cur_priv);
            if (to_super) begin
                st_d.spie    = cur_sie;
                st_d.spp     = cur_priv[0];
                st_d.sie     = 1'b0;
                st_d.scause  = cause_word;
                st_d.sepc    = trap_pc;
                st_d.stval   = tval_word;
                st_d.next_pc = handler_pc[1];
            end else begin
                st_d.mpie    = cur_mie;
                st_d.mpp     = cur_priv;
                st_d.mie     = 1'b0;
                st_d.mcause  = cause_word;
                st_d.mepc    = trap_pc;
                st_d.mtval   = tval_word;
                st_d.next_pc = handler_pc[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.priv <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign priv       = st_q.priv;
    assign mie        = st_q.mie;
    assign mpie       = st_q.mpie;
    assign mpp        = st_q.mpp;
    assign sie        = st_q.sie;
    assign spie       = st_q.spie;
    assign spp        = st_q.spp;
    assign mcause     = st_q.mcause;
    assign mepc       = st_q.mepc;
    assign mtval      = st_q.mtval;
    assign scause     = st_q.scause;
    assign sepc       = st_q.sepc;
    assign stval      = st_q.stval;
    assign next_pc    = st_q.next_pc;
    assign trap_done  = st_q.done;
    assign resv_clear = st_q.resv_clr;

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> trap_done);                                            // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> !trap_done && $stable(mepc) && $stable(sepc) && $stable(priv)); // R10
    AST_M_STAYS_M: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && cur_priv == PRIV_M |=> priv == PRIV_M);                 // R1
    AST_HIGH_CAUSE_M: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && 32'(trap_cause) >= XLEN |=> priv == PRIV_M);            // R2
    AST_IE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done |-> (priv == PRIV_M) ? !mie : !sie);                        // R3
    AST_CAUSE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done && priv == PRIV_M |-> mcause[XLEN-1] == $past(trap_async)); // R4
    AST_EPC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done && priv == PRIV_S |-> sepc == $past(trap_pc));              // R8
    AST_RESV_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        resv_clear |-> trap_done && priv != $past(cur_priv));                 // R9

endmodule

// File: tb/trap_entry_ctrl_test.sv
module trap_entry_ctrl_test;

    localparam int XLEN    = 32;
    localparam int CAUSE_W = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               trap_valid = 1'b0;
    logic               trap_async = 1'b0;
    logic [CAUSE_W-1:0] trap_cause = '0;
    logic [XLEN-1:0]    trap_addr = '0;
    logic [XLEN-1:0]    trap_pc = '0;
    logic [1:0]         cur_priv = 2'd3;
    logic               cur_mie = 1'b0;
    logic               cur_sie = 1'b0;
    logic [XLEN-1:0]    exc_deleg = '0;
    logic [XLEN-1:0]    int_deleg = '0;
    logic [XLEN-1:0]    m_tvec = '0;
    logic [XLEN-1:0]    s_tvec = '0;
    logic [1:0]         priv;
    logic               mie, mpie, sie, spie, spp;
    logic [1:0]         mpp;
    logic [XLEN-1:0]    mcause, mepc, mtval, scause, sepc, stval, next_pc;
    logic               trap_done, resv_clear;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // Bench-side image of the level that was not the destination
    logic [XLEN-1:0] e_mcause = '0, e_mepc = '0, e_mtval = '0;
    logic [XLEN-1:0] e_scause = '0, e_sepc = '0, e_stval = '0;
    logic            e_mie = 0, e_mpie = 0, e_sie = 0, e_spie = 0, e_spp = 0;
    logic [1:0]      e_mpp = '0;

    always #10 clk = ~clk;

    trap_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) uut (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_async(trap_async),
        .trap_cause(trap_cause), .trap_addr(trap_addr), .trap_pc(trap_pc),
        .cur_priv(cur_priv), .cur_mie(cur_mie), .cur_sie(cur_sie),
        .exc_deleg(exc_deleg), .int_deleg(int_deleg), .m_tvec(m_tvec), .s_tvec(s_tvec),
        .priv(priv), .mie(mie), .mpie(mpie), .mpp(mpp), .sie(sie), .spie(spie), .spp(spp),
        .mcause(mcause), .mepc(mepc), .mtval(mtval), .scause(scause), .sepc(sepc),
        .stval(stval), .next_pc(next_pc), .trap_done(trap_done), .resv_clear(resv_clear)
    );

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit addr_cause(input int c);
        return c == 0 || c == 1 || c == 4 || c == 5 || c == 6 || c == 7 ||
               c == 12 || c == 13 || c == 15;
    endfunction

    task automatic do_trap(input logic [1:0] p, input bit a, input int c,
                           input logic [XLEN-1:0] addr, input logic [XLEN-1:0] pc);
        int ec;
        bit to_s;
        logic [XLEN-1:0] dm, cw, tw, tv, epc;
        logic [1:0] dp;
        ec = c;
        if (!a && c == 8) ec = (p == 2'd3) ? 11 : (p == 2'd1) ? 9 : 8;
        dm = a ? int_deleg : exc_deleg;
        to_s = (p != 2'd3) && (ec < XLEN) && dm[ec % XLEN];
        cw = (XLEN'(a) << (XLEN - 1)) | XLEN'(ec);
        tw = (!a && addr_cause(ec)) ? addr : '0;
        tv = to_s ? s_tvec : m_tvec;
        epc = (tv & ~XLEN'(3)) + ((a && tv[1:0] == 2'd1) ? XLEN'(ec * 4) : '0);
        dp = to_s ? 2'd1 : 2'd3;

        @(negedge clk);
        cur_priv = p; trap_async = a; trap_cause = CAUSE_W'(c);
        trap_addr = addr; trap_pc = pc;
        cur_mie = c[0]; cur_sie = c[1];
        trap_valid = 1'b1;
        if (to_s) begin
            e_spie = cur_sie; e_spp = p[0]; e_sie = 0;
            e_scause = cw; e_sepc = pc; e_stval = tw;
        end else begin
            e_mpie = cur_mie; e_mpp = p; e_mie = 0;
            e_mcause = cw; e_mepc = pc; e_mtval = tw;
        end
        @(negedge clk);
        trap_valid = 1'b0;
        chk("R10 done pulse", XLEN'(trap_done), 1);
        chk("R1 R2 R7 destination", XLEN'(priv), XLEN'(dp));
        chk("R3 mie", XLEN'(mie), XLEN'(e_mie));
        chk("R3 mpie", XLEN'(mpie), XLEN'(e_mpie));
        chk("R3 mpp", XLEN'(mpp), XLEN'(e_mpp));
        chk("R3 sie", XLEN'(sie), XLEN'(e_sie));
        chk("R3 spie", XLEN'(spie), XLEN'(e_spie));
        chk("R3 spp", XLEN'(spp), XLEN'(e_spp));
        chk("R4 R7 mcause", mcause, e_mcause);
        chk("R4 R7 scause", scause, e_scause);
        chk("R8 mepc", mepc, e_mepc);
        chk("R8 sepc", sepc, e_sepc);
        chk("R6 mtval", mtval, e_mtval);
        chk("R6 stval", stval, e_stval);
        chk("R5 next_pc", next_pc, epc);
        chk("R9 resv_clear", XLEN'(resv_clear), XLEN'(dp != p));
        // Inputs move without a strobe: nothing may change
        trap_pc = ~pc; trap_addr = ~addr; cur_priv = ~p;
        @(negedge clk);
        chk("R10 done low", XLEN'(trap_done), 0);
        chk("R10 mepc held", mepc, e_mepc);
        chk("R10 priv held", XLEN'(priv), XLEN'(dp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset priv", XLEN'(priv), 3);
        chk("R10 reset mcause", mcause, 0);
        chk("R10 reset next_pc", next_pc, 0);
        chk("R10 reset done", XLEN'(trap_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", XLEN'(trap_done), 0);

        for (int vi = 0; vi < 2; vi++) begin
            m_tvec = (vi == 0) ? 32'h8000_0101 : 32'h8000_0200;
            s_tvec = (vi == 0) ? 32'h4000_0203 : 32'h4000_0301;
            for (int di = 0; di < 4; di++) begin
                case (di)
                    0: begin exc_deleg = '1;           int_deleg = '1;           end
                    1: begin exc_deleg = 32'h0000_0200; int_deleg = 32'h0000_0200; end // R7 bit 9 only
                    2: begin exc_deleg = 32'h0000_0100; int_deleg = 32'hA5A5_5A5A; end // R7 bit 8 only
                    default: begin exc_deleg = '0;      int_deleg = '0;           end
                endcase
                for (int pi = 0; pi < 3; pi++) begin
                    for (int a = 0; a < 2; a++) begin
                        for (int c = 0; c < 40; c++) begin
                            do_trap((pi == 2) ? 2'd3 : 2'(pi), a[0], c,
                                    32'hF00D_0000 + 32'(c * 16 + di),
                                    32'h1000_0000 + 32'(c * 4 + pi * 256 + a * 8192));
                        end
                    end
                end
            end
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule